// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block makes the serial clock of an SPI master from the fixed main clock. Division happens in two stages. A prescaler divides by a power of two, `2 << div`, with `div` from 0 to 3. Its output, one pulse per prescaler period, drives a half-period counter. That counter toggles SCK every `brg + 1` pulses, with `brg` from 4 to 63. One full SCK period is therefore `(2 << div) * 2 * (brg + 1)` main-clock cycles.

The shift engine holds `run` high while it has bits to move. It receives two single-cycle strobes: one on each leading edge of SCK and one on each trailing edge. The engine lowers `run` during the final bit. The generator then finishes that bit and parks SCK at its idle level.

A combinational helper maps a requested division ratio, the main clock rate over the wanted SCK rate, to a `div`/`brg` pair. It clamps requests that are outside the reachable range.

Top module: `sck_baud_gen`

## Requirements
- R1: With `en` high and the generator idle, a cycle in which `run` is high starts a bit. Let H = `(2 << div) * (brg + 1)`. The leading-edge strobe fires H cycles after the start cycle, and every following strobe fires H cycles after the previous one. A full SCK period is therefore 2H.
- R2: The extreme settings give the extreme ratios. `div`=0 with `brg`=4 divides the main clock by 20. `div`=3 with `brg`=63 divides it by 2048.
- R3: A `brg_in` value below 4 behaves exactly like 4.
- R4: `div_in`, `brg_in` and `cpol` are captured only while `en` is low. Changes to them while `en` is high do not alter the SCK timing or level.
- R5: The idle level of SCK equals the captured `cpol`. A leading edge moves SCK to the opposite of `cpol`, and a trailing edge moves it back to `cpol`.
- R6: SCK toggles only while a bit is in progress. `run` is examined at every trailing edge. If `run` is low there, SCK stays at the idle level and no further strobe fires.
- R7: `lead_stb` and `trail_stb` are each one cycle wide and never high together. Each is high exactly in the cycle where SCK takes its new level. They strictly alternate, beginning with a leading strobe.
- R8: Lowering `en` aborts a bit in progress. From the next cycle on, SCK is at the idle level and both strobes are low.
- R9: Let b(d) = `ratio_in >> (2 + d)`. The helper tries `d` = 0, 1, 2, 3 in turn and returns the first `d` for which b(d) is no more than 64, with `ratio_brg` = b(d) - 1.
- R10: The helper clamps out-of-range requests. If b(0) < 5, it returns `div` 0 and `brg` 4. If no `d` fits, it returns `div` 3 and `brg` 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; configuration is captured while low |
| cpol | input | 1 | Idle level of SCK |
| div_in | input | 2 | Prescaler exponent, divide by 2 << div |
| brg_in | input | 6 | Half-period count minus one (floor 4) |
| run | input | 1 | Transfer request from the shift engine |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle leading-edge strobe |
| trail_stb | output | 1 | One-cycle trailing-edge strobe |
| ratio_in | input | 16 | Requested main-to-SCK division ratio |
| ratio_div | output | 2 | Suggested prescaler exponent |
| ratio_brg | output | 6 | Suggested half-period value |

## Verification
The divider is run at the fastest and slowest settings and at a middle setting with a nonzero prescaler. Each run measures the cycle position of every strobe, so an error in either stage shows up as a wrong spacing. Both polarities are used, with runs of one to three bits, to separate edge direction from idle level and to catch extra or missing bits at the stop point. Further cases cover a below-floor `brg`, configuration changes while enabled, and an abort by dropping `en`. Each of these must leave the timing of the captured setting unchanged. The helper is given ratios below the reachable range, at each stage boundary, inside a later stage and beyond the slowest setting.

// File: rtl/sck_baud_gen.sv
module sck_baud_gen #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int RATIO_W = 16,
  parameter int BRG_MIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cpol,
  input  logic [DIV_W-1:0]   div_in,
  input  logic [BRG_W-1:0]   brg_in,
  input  logic               run,
  output logic               sck,
  output logic               lead_stb,
  output logic               trail_stb,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic [DIV_W-1:0]   ratio_div,
  output logic [BRG_W-1:0]   ratio_brg
);
  localparam int MAX_DIV = (1 << DIV_W) - 1;
  localparam int PRE_W   = 1 << DIV_W;
  localparam int BRG_MAX = (1 << BRG_W) - 1;

  logic [DIV_W-1:0] cfg_div;
  logic [BRG_W-1:0] cfg_brg;
  logic             cfg_cpol;
  logic [PRE_W-1:0] pre_cnt, pre_max;
  logic [BRG_W-1:0] half_cnt;
  logic             active, phase, tick, half_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_div  <= '0;
      cfg_brg  <= BRG_W'(BRG_MIN);
      cfg_cpol <= 1'b0;
    end else if (!en) begin
      cfg_div  <= div_in;
      cfg_brg  <= (brg_in < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : brg_in;
      cfg_cpol <= cpol;
    end
  end

  assign pre_max   = {PRE_W{1'b1}} >> (DIV_W'(MAX_DIV) - cfg_div);
  assign tick      = active && (pre_cnt == pre_max);
  assign half_done = tick && (half_cnt == cfg_brg);
  assign sck       = cfg_cpol ^ phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      active    <= 1'b0;
      phase     <= 1'b0;
      pre_cnt   <= '0;
      half_cnt  <= '0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (!active) begin
        active   <= run;
        pre_cnt  <= '0;
        half_cnt <= '0;
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) half_cnt <= half_done ? '0 : half_cnt + 1'b1;
        if (half_done) begin
          phase <= ~phase;
          if (!phase) lead_stb <= 1'b1;
          else begin
            trail_stb <= 1'b1;
            if (!run) active <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    logic [RATIO_W-1:0] b;
    logic found;
    found     = 1'b0;
    ratio_div = DIV_W'(MAX_DIV);
    ratio_brg = BRG_W'(BRG_MAX);
    for (int d = 0; d <= MAX_DIV; d++) begin
      b = ratio_in >> (2 + d);
      if (!found) begin
        if (d == 0 && b < RATIO_W'(BRG_MIN + 1)) begin
          found     = 1'b1;
          ratio_div = '0;
          ratio_brg = BRG_W'(BRG_MIN);
        end else if (b <= RATIO_W'(BRG_MAX + 1)) begin
          found     = 1'b1;
          ratio_div = DIV_W'(d);
          ratio_brg = BRG_W'(b - 1'b1);
        end
      end
    end
  end

  logic last_lead;
  always_ff @(posedge clk) begin
    if (!rst_n || !en) last_lead <= 1'b0;
    else if (lead_stb) last_lead <= 1'b1;
    else if (trail_stb) last_lead <= 1'b0;
  end

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));
  assert_lead_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> !last_lead);
  assert_trail_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> last_lead);
  assert_lead_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);
  assert_sck_moves_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(sck)) |-> (lead_stb || trail_stb));
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck == cfg_cpol));
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(cfg_div) && $stable(cfg_brg) && $stable(cfg_cpol)));
  assert_brg_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_brg >= BRG_W'(BRG_MIN));
  assert_helper_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_brg >= BRG_W'(BRG_MIN));
endmodule

// File: tb/tb_sck_baud_gen.sv
`timescale 1ns/1ps
module tb_sck_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cpol = 1'b0, run = 1'b0;
  logic [1:0] div_in = '0;
  logic [5:0] brg_in = 6'd4;
  logic [15:0] ratio_in = '0;
  logic sck, lead_stb, trail_stb;
  logic [1:0] ratio_div;
  logic [5:0] ratio_brg;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sck_baud_gen dut (.clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .div_in(div_in),
    .brg_in(brg_in), .run(run), .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .ratio_in(ratio_in), .ratio_div(ratio_div), .ratio_brg(ratio_brg));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int d, input int b, input int c);
    en = 1'b0; run = 1'b0; div_in = 2'(d); brg_in = 6'(b); cpol = c[0];
    @(negedge clk); @(negedge clk);
  endtask

  // Starts a transfer of nb bits with the captured setting and checks strobe timing.
  task automatic run_bits(input int h, input int c, input int nb, input string tag);
    int n = 0, leads = 0, trails = 0, idx = 0;
    logic prev = sck;
    bit bad = 0;
    chk(sck == c[0], {tag, " R5 idle before"}, sck, c);
    en = 1'b1; run = 1'b1;
    while (trails < nb && n < 4 * h * nb + 100) begin
      @(negedge clk); n++;
      if (lead_stb && trail_stb) bad = 1;
      if (sck != prev && !(lead_stb || trail_stb)) bad = 1;
      prev = sck;
      if (lead_stb || trail_stb) begin
        chk(n == (idx + 1) * h + 1, {tag, " R1 strobe position"}, n, (idx + 1) * h + 1);
        idx++;
      end
      if (lead_stb) begin
        chk(leads == trails && sck == !c[0], {tag, " R5 R7 leading edge"}, sck, !c[0]);
        leads++;
        if (leads == nb) run = 1'b0;
      end
      if (trail_stb) begin
        chk(leads == trails + 1 && sck == c[0], {tag, " R5 R7 trailing edge"}, sck, c);
        trails++;
      end
    end
    chk(trails == nb, {tag, " R6 bit count"}, trails, nb);
    chk(!bad, {tag, " R7 strobe shape"}, bad, 0);
    repeat (2 * h + 4) begin
      @(negedge clk);
      if (lead_stb || trail_stb || sck != c[0]) bad = 1;
    end
    chk(!bad, {tag, " R6 idle after last bit"}, bad, 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sck == 1'b0 && !lead_stb && !trail_stb, "R5 reset state", {sck, lead_stb, trail_stb}, 0);
  endtask

  task automatic t_fast;
    load(0, 4, 0);
    run_bits(10, 0, 3, "fastest");
  endtask

  task automatic t_slow;
    load(3, 63, 1);
    run_bits(1024, 1, 1, "R2 slowest");
  endtask

  task automatic t_mid;
    load(1, 10, 1);
    run_bits(44, 1, 2, "R1 mid");
  endtask

  task automatic t_floor;
    load(0, 1, 0);
    run_bits(10, 0, 1, "R3 brg floor");
  endtask

  task automatic t_frozen;
    load(0, 5, 0);
    en = 1'b1;
    @(negedge clk);
    div_in = 2'd2; brg_in = 6'd30; cpol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b0, "R4 polarity frozen", sck, 0);
    run_bits(12, 0, 1, "R4 frozen");
  endtask

  task automatic t_abort;
    int n = 0;
    bit bad = 0;
    load(0, 4, 1);
    en = 1'b1; run = 1'b1;
    while (!lead_stb && n < 100) begin @(negedge clk); n++; end
    chk(sck == 1'b0, "R8 in progress before abort", sck, 0);
    en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b1 && !lead_stb && !trail_stb, "R8 abort to idle", sck, 1);
    repeat (40) begin
      @(negedge clk);
      if (lead_stb || trail_stb || sck != 1'b1) bad = 1;
    end
    chk(!bad, "R8 quiet while disabled", bad, 0);
    run = 1'b0;
  endtask

  task automatic hlp(input int r, input int ed, input int eb, input string req);
    ratio_in = 16'(r);
    #1;
    chk(ratio_div == 2'(ed) && ratio_brg == 6'(eb), req, {ratio_div, ratio_brg}, {ed[1:0], eb[5:0]});
  endtask

  task automatic t_helper;
    hlp(20, 0, 4, "R9 fastest exact");
    hlp(10, 0, 4, "R10 too fast");
    hlp(256, 0, 63, "R9 stage0 top");
    hlp(260, 1, 31, "R9 stage1");
    hlp(1000, 2, 61, "R9 stage2");
    hlp(2048, 3, 63, "R9 slowest exact");
    hlp(4000, 3, 63, "R10 too slow");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fast;
    t_slow;
    t_mid;
    t_floor;
    t_frozen;
    t_abort;
    t_helper;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule